// File: doc/BRIEF.md
# Bridge Claim Decoder

This block sits on the downstream path of a transparent bus bridge. For every cycle that the upstream link presents, it decides whether the bridge takes that cycle onto its secondary bus. A cycle can be taken in one of two ways. It is taken positively when its address falls in one of the bridge's programmed windows or in a legacy display range. It is taken subtractively when no positive match occurs and no other agent has claimed the cycle by the end of a one-cycle sample window.

The block is fully pipelined and accepts one request per cycle. The positive decision appears one cycle after the request. The subtractive decision and the forward strobe appear two cycles after it. During the cycle between those two points, the claim line from the other agents is sampled.

An optional legacy-alias mask keeps positive IO forwarding off the upper three quarters of every 1 KB IO block. Those cycles can still be taken subtractively. The legacy display ranges have a separate enable and override that mask.

Top module: `bridge_claim_decoder`

## Requirements
- R1: While reset is low, and in the first cycle after it, `pos_claim_o`, `sub_claim_o` and `fwd_o` are all 0.
- R2: A memory request (`req_is_io_i`=0) whose address lies in [`mem_base_i`, `mem_limit_i`] raises `pos_claim_o` for exactly the cycle after the request, but only if `mem_space_en_i` was 1 in the request cycle.
- R3: An IO request whose address lies in [`io_base_i`, `io_limit_i`] raises `pos_claim_o` one cycle after the request, but only if `io_space_en_i` is 1.
- R4: Both window bounds are inclusive. A window whose limit is below its base matches no address.
- R5: When `isa_en_i` is 1, an IO address whose bits [9:8] are not both 0 (offsets 100h..3FFh in a 1 KB block) is not claimed positively through the IO window.
- R6: When `vga_en_i` is 1 and the matching space enable is 1, the following are claimed positively regardless of the windows and of the alias mask: memory A0000h..BFFFFh, and IO whose bits [9:0] lie in 3B0h..3BBh or 3C0h..3DFh.
- R7: A memory request that is not positively claimed, with `mem_space_en_i`=1, raises `sub_claim_o` two cycles after the request. This happens only if `other_claim_i` is 0 in the cycle after the request.
- R8: An IO request that is not positively claimed, with `io_space_en_i`=1 and address bits above bit 15 all 0, is claimed subtractively under the same rule. An IO request with any of those upper bits set is never claimed. This applies to IO cycles blocked by R5.
- R9: `other_claim_i`=1 in the sample cycle suppresses the subtractive claim of that request.
- R10: A request that raised `pos_claim_o` never raises `sub_claim_o`.
- R11: `fwd_o` is 1 two cycles after a request exactly when that request was claimed, positively or subtractively.
- R12: For a memory request with `req_wide_i`=0, address bits [63:32] are ignored (treated as 0). With `req_wide_i`=1, the full address is decoded.
- R13: Requests on consecutive cycles are decoded independently. Each request uses the configuration and the sample-cycle claim line that belong to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | ADDR_W | Request address |
| req_is_io_i | input | 1 | 1 = IO cycle, 0 = memory cycle |
| req_wide_i | input | 1 | Memory cycle carries a full-width address |
| other_claim_i | input | 1 | Another agent claimed the request of the previous cycle |
| mem_base_i | input | ADDR_W | Memory window base (inclusive) |
| mem_limit_i | input | ADDR_W | Memory window limit (inclusive) |
| io_base_i | input | IO_W | IO window base (inclusive) |
| io_limit_i | input | IO_W | IO window limit (inclusive) |
| mem_space_en_i | input | 1 | Memory space enable |
| io_space_en_i | input | 1 | IO space enable |
| isa_en_i | input | 1 | Legacy IO alias mask enable |
| vga_en_i | input | 1 | Legacy display range enable |
| pos_claim_o | output | 1 | Positive claim, one cycle after the request |
| sub_claim_o | output | 1 | Subtractive claim, two cycles after the request |
| fwd_o | output | 1 | Forward strobe, two cycles after a claimed request |

## Verification
The hardest situation to reach is an overlap in the pipeline. In it, a request's subtractive decision depends on the claim line, and that line is driven in the same cycle as the next request, whose configuration may differ. The stimulus issues a request on every cycle. The claim line is driven one cycle behind each request and the configuration is driven with it, so every subtractive outcome sits next to an unrelated positive or blocked one. Alias addresses that hit both the legacy display ranges and the masked region are placed inside the IO window. This shows the precedence of the display enable.

// File: rtl/bridge_dec_pkg.sv
package bridge_dec_pkg;

    // Legacy display memory range (inclusive)
    localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
    localparam logic [31:0] VGA_MEM_HI = 32'h000B_FFFF;
    // Legacy display IO ranges on the 10-bit decoded offset (inclusive)
    localparam logic [9:0]  VGA_IO_A_LO = 10'h3B0;
    localparam logic [9:0]  VGA_IO_A_HI = 10'h3BB;
    localparam logic [9:0]  VGA_IO_B_LO = 10'h3C0;
    localparam logic [9:0]  VGA_IO_B_HI = 10'h3DF;

    // Stage 1: request decoded, waiting out the claim sample cycle
    typedef struct packed {
        logic valid;
        logic pos;
        logic sub_ok;
    } stage1_t;

    // Stage 2: final decision
    typedef struct packed {
        logic sub;
        logic fwd;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } dec_state_t;

endpackage

// File: rtl/bdec_window.sv
module bdec_window #(
    parameter int W = 64
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] limit_i,
    input  logic [W-1:0] addr_i,
    output logic         hit_o
);
    logic enabled;
    logic above_base;
    logic below_limit;

    always_comb begin
        enabled     = (limit_i >= base_i);
        above_base  = (addr_i >= base_i);
        below_limit = (addr_i <= limit_i);
        hit_o       = enabled && above_base && below_limit;
    end
endmodule

// File: rtl/bdec_legacy.sv
module bdec_legacy
    import bridge_dec_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              is_io_i,
    input  logic              isa_en_i,
    input  logic              vga_en_i,
    output logic              isa_block_o,
    output logic              vga_hit_o
);
    localparam int HI_W = ADDR_W - 32;

    logic [9:0] io_off;
    logic       vga_io;
    logic       vga_mem;
    logic       upper_zero;

    generate
        if (ADDR_W > 32) begin : g_upper
            assign upper_zero = (addr_i[ADDR_W-1:32] == {HI_W{1'b0}});
        end else begin : g_no_upper
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        io_off  = addr_i[9:0];
        vga_io  = ((io_off >= VGA_IO_A_LO) && (io_off <= VGA_IO_A_HI)) ||
                  ((io_off >= VGA_IO_B_LO) && (io_off <= VGA_IO_B_HI));
        vga_mem = upper_zero &&
                  (addr_i[31:0] >= VGA_MEM_LO) && (addr_i[31:0] <= VGA_MEM_HI);
        isa_block_o = isa_en_i && is_io_i && (io_off[9:8] != 2'b00);
        vga_hit_o   = vga_en_i && (is_io_i ? vga_io : vga_mem);
    end
endmodule

// File: rtl/bridge_claim_decoder.sv
module bridge_claim_decoder
    import bridge_dec_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IO_W   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_is_io_i,
    input  logic              req_wide_i,
    input  logic              other_claim_i,
    input  logic [ADDR_W-1:0] mem_base_i,
    input  logic [ADDR_W-1:0] mem_limit_i,
    input  logic [IO_W-1:0]   io_base_i,
    input  logic [IO_W-1:0]   io_limit_i,
    input  logic              mem_space_en_i,
    input  logic              io_space_en_i,
    input  logic              isa_en_i,
    input  logic              vga_en_i,
    output logic              pos_claim_o,
    output logic              sub_claim_o,
    output logic              fwd_o
);
    localparam int NARROW_W = 32;
    localparam int IO_HI_W  = ADDR_W - IO_W;

    logic [ADDR_W-1:0] eff_addr;
    logic [IO_W-1:0]   io_addr;
    logic              io_fits;
    logic              mem_win_hit;
    logic              io_win_hit;
    logic              isa_block;
    logic              vga_hit;
    logic              pos_mem;
    logic              pos_io;
    logic              pos_any;
    logic              sub_ok;

    dec_state_t state_d, state_q;

    // Narrow memory cycles drop the upper address half
    generate
        if (ADDR_W > NARROW_W) begin : g_narrow
            assign eff_addr = (req_wide_i || req_is_io_i) ? req_addr_i
                            : {{(ADDR_W-NARROW_W){1'b0}}, req_addr_i[NARROW_W-1:0]};
        end else begin : g_flat
            assign eff_addr = req_addr_i;
        end
        if (ADDR_W > IO_W) begin : g_io_range
            assign io_fits = (req_addr_i[ADDR_W-1:IO_W] == {IO_HI_W{1'b0}});
        end else begin : g_io_full
            assign io_fits = 1'b1;
        end
    endgenerate

    assign io_addr = req_addr_i[IO_W-1:0];

    bdec_window #(.W(ADDR_W)) u_mem_win (
        .base_i  (mem_base_i),
        .limit_i (mem_limit_i),
        .addr_i  (eff_addr),
        .hit_o   (mem_win_hit)
    );

    bdec_window #(.W(IO_W)) u_io_win (
        .base_i  (io_base_i),
        .limit_i (io_limit_i),
        .addr_i  (io_addr),
        .hit_o   (io_win_hit)
    );

    bdec_legacy #(.ADDR_W(ADDR_W)) u_legacy (
        .addr_i      (eff_addr),
        .is_io_i     (req_is_io_i),
        .isa_en_i    (isa_en_i),
        .vga_en_i    (vga_en_i),
        .isa_block_o (isa_block),
        .vga_hit_o   (vga_hit)
    );

    always_comb begin
        pos_mem = !req_is_io_i && mem_space_en_i && (mem_win_hit || vga_hit);
        pos_io  = req_is_io_i && io_space_en_i && io_fits &&
                  ((io_win_hit && !isa_block) || vga_hit);
        pos_any = pos_mem || pos_io;
        sub_ok  = req_is_io_i ? (io_space_en_i && io_fits) : mem_space_en_i;

        state_d = state_q;
        state_d.s1.valid  = req_valid_i;
        state_d.s1.pos    = req_valid_i && pos_any;
        state_d.s1.sub_ok = req_valid_i && !pos_any && sub_ok;
        state_d.s2.sub    = state_q.s1.sub_ok && !other_claim_i;
        state_d.s2.fwd    = state_q.s1.pos || state_d.s2.sub;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pos_claim_o = state_q.s1.pos;
    assign sub_claim_o = state_q.s2.sub;
    assign fwd_o       = state_q.s2.fwd;
endmodule

// File: rtl/bridge_claim_decoder_chk.sv
module bridge_claim_decoder_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_valid_i,
    input logic req_is_io_i,
    input logic mem_space_en_i,
    input logic io_space_en_i,
    input logic other_claim_i,
    input logic pos_claim_o,
    input logic sub_claim_o,
    input logic fwd_o
);
    assert_pos_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_claim_o |-> $past(req_valid_i));

    assert_pos_mem_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_claim_o && !$past(req_is_io_i)) |-> $past(mem_space_en_i));

    assert_pos_io_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_claim_o && $past(req_is_io_i)) |-> $past(io_space_en_i));

    assert_sub_follows_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sub_claim_o |-> $past(req_valid_i, 2));

    assert_sub_free_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sub_claim_o |-> !$past(other_claim_i));

    assert_no_double_claim_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sub_claim_o |-> !$past(pos_claim_o));

    assert_fwd_has_claim_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fwd_o |-> (sub_claim_o || $past(pos_claim_o)));

    assert_pos_leads_fwd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pos_claim_o |=> fwd_o);
endmodule

bind bridge_claim_decoder bridge_claim_decoder_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_is_io_i    (req_is_io_i),
    .mem_space_en_i (mem_space_en_i),
    .io_space_en_i  (io_space_en_i),
    .other_claim_i  (other_claim_i),
    .pos_claim_o    (pos_claim_o),
    .sub_claim_o    (sub_claim_o),
    .fwd_o          (fwd_o)
);

// File: tb/bridge_claim_decoder_test.sv
`timescale 1ns/1ps
module bridge_claim_decoder_test;
    localparam int AW = 64;
    localparam int IW = 16;

    typedef struct {
        bit    pos;
        bit    sub;
        bit    fwd;
        string tag;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req_valid = 0;
    logic [AW-1:0] req_addr = '0;
    logic          req_io = 0;
    logic          req_wide = 0;
    logic          other = 0;
    logic [AW-1:0] mbase = '0, mlimit = '0;
    logic [IW-1:0] ibase = '0, ilimit = '0;
    logic          men = 0, ien = 0, isa = 0, vga = 0;
    logic          pos_o, sub_o, fwd_o;

    // configuration shadows, applied with each request
    logic [AW-1:0] c_mbase, c_mlimit;
    logic [IW-1:0] c_ibase, c_ilimit;
    bit            c_men, c_ien, c_isa, c_vga;

    exp_t exp_q[$];
    bit   other_next = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   running = 0;

    always #2 clk = ~clk;

    bridge_claim_decoder #(.ADDR_W(AW), .IO_W(IW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_is_io_i(req_io), .req_wide_i(req_wide), .other_claim_i(other),
        .mem_base_i(mbase), .mem_limit_i(mlimit), .io_base_i(ibase), .io_limit_i(ilimit),
        .mem_space_en_i(men), .io_space_en_i(ien), .isa_en_i(isa), .vga_en_i(vga),
        .pos_claim_o(pos_o), .sub_claim_o(sub_o), .fwd_o(fwd_o)
    );

    // Reference model written from the requirements
    function automatic void model(input logic [AW-1:0] a, input bit io, input bit wide,
                                  input bit oth, output bit p, output bit s);
        logic [AW-1:0] ea;
        logic [9:0]    off;
        bit win, legacy, masked, fits, elig;
        ea  = (!io && !wide) ? {32'h0, a[31:0]} : a;
        off = a[9:0];
        if (io) begin
            fits   = (a[AW-1:IW] == '0);
            win    = (c_ilimit >= c_ibase) && (a[IW-1:0] >= c_ibase) && (a[IW-1:0] <= c_ilimit);
            masked = c_isa && (off >= 10'h100);
            legacy = c_vga && ((off >= 10'h3B0 && off <= 10'h3BB) || (off >= 10'h3C0 && off <= 10'h3DF));
            p      = c_ien && fits && ((win && !masked) || legacy);
            elig   = c_ien && fits;
        end else begin
            win    = (c_mlimit >= c_mbase) && (ea >= c_mbase) && (ea <= c_mlimit);
            legacy = c_vga && (ea >= 64'hA0000) && (ea <= 64'hBFFFF);
            p      = c_men && (win || legacy);
            elig   = c_men;
        end
        s = !p && elig && !oth;
    endfunction

    task automatic drive(input bit v, input logic [AW-1:0] a, input bit io, input bit wide,
                         input bit oth, input string tag);
        exp_t e;
        bit p, s;
        @(negedge clk);
        other     = other_next;
        req_valid = v;
        req_addr  = a;
        req_io    = io;
        req_wide  = wide;
        mbase = c_mbase; mlimit = c_mlimit; ibase = c_ibase; ilimit = c_ilimit;
        men = c_men; ien = c_ien; isa = c_isa; vga = c_vga;
        other_next = v ? oth : 1'b0;
        if (v) model(a, io, wide, oth, p, s);
        else begin p = 0; s = 0; end
        e.pos = p; e.sub = s; e.fwd = p || s; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [AW-1:0] a, input bit io, input bit wide,
                        input bit oth, input string tag);
        drive(1'b1, a, io, wide, oth, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0, 1'b0, "idle");
    endtask

    // Monitor: pops one expectation per cycle, late fields checked a cycle later
    initial begin
        exp_t cur, prev;
        prev.pos = 0; prev.sub = 0; prev.fwd = 0; prev.tag = "R1";
        wait (running);
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else begin cur.pos = 0; cur.sub = 0; cur.fwd = 0; cur.tag = "idle"; end
            n_cmp++;
            if (pos_o !== cur.pos || sub_o !== prev.sub || fwd_o !== prev.fwd) begin
                n_bad++;
                if (pos_o !== cur.pos)
                    $display("FAIL %s pos_claim got %0b exp %0b", cur.tag, pos_o, cur.pos);
                if (sub_o !== prev.sub)
                    $display("FAIL %s sub_claim got %0b exp %0b", prev.tag, sub_o, prev.sub);
                if (fwd_o !== prev.fwd)
                    $display("FAIL %s fwd got %0b exp %0b", prev.tag, fwd_o, prev.fwd);
            end
            prev = cur;
        end
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired got running exp done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        c_mbase = 64'h8000_0000; c_mlimit = 64'h8FFF_FFFF;
        c_ibase = 16'h1000;      c_ilimit = 16'h1FFF;
        c_men = 1; c_ien = 1; c_isa = 0; c_vga = 0;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;  // R1: outputs quiet in reset
        if (pos_o !== 0 || sub_o !== 0 || fwd_o !== 0) begin
            n_bad++;
            $display("FAIL R1 reset outputs got %0b%0b%0b exp 000", pos_o, sub_o, fwd_o);
        end
        @(negedge clk);
        rst_n = 1;
        running = 1;

        // R2 / R4: window interior and inclusive edges
        send(64'h8123_4560, 0, 1, 0, "R2 mem in window");
        send(64'h8000_0000, 0, 1, 0, "R4 mem base edge");
        send(64'h8FFF_FFFF, 0, 1, 1, "R4 mem limit edge");
        send(64'h9000_0000, 0, 1, 0, "R7 mem above limit subtractive");
        send(64'h0000_1000, 0, 1, 1, "R9 mem other agent claims");
        // R3 / R5 / R8: IO window and alias mask
        send(64'h1010, 1, 0, 0, "R3 io in window");
        send(64'h1110, 1, 0, 0, "R5 io alias with mask off");
        c_isa = 1;
        send(64'h1110, 1, 0, 0, "R5 io alias masked taken subtractively");
        send(64'h1310, 1, 0, 1, "R9 io masked and other claims");
        send(64'h10F0, 1, 0, 0, "R5 io low offset still positive");
        send(64'h0500, 1, 0, 0, "R8 io outside window subtractive");
        send(64'h1_0010, 1, 0, 0, "R8 io above 16 bits never claimed");
        // R6: legacy display ranges
        send(64'hA0000, 0, 0, 0, "R6 display mem with enable off");
        c_vga = 1;
        send(64'hA0000, 0, 0, 0, "R6 display mem low edge");
        send(64'hBFFFF, 0, 0, 1, "R6 display mem high edge");
        send(64'hC0000, 0, 0, 0, "R6 display mem above range");
        send(64'h03B0, 1, 0, 0, "R6 display io first range");
        send(64'h03BC, 1, 0, 0, "R6 display io gap");
        send(64'h03DF, 1, 0, 0, "R6 display io second range end");
        send(64'h13C0, 1, 0, 0, "R6 display alias overrides mask");
        send(64'h03E0, 1, 0, 0, "R6 display io above range");
        c_vga = 0; c_isa = 0;
        // R2 / R3: space enables
        c_men = 0;
        send(64'h8000_1000, 0, 1, 0, "R2 mem disabled no claim");
        send(64'h9000_0000, 0, 1, 0, "R7 mem disabled no subtractive");
        c_men = 1; c_ien = 0;
        send(64'h1010, 1, 0, 0, "R3 io disabled no claim");
        send(64'h0500, 1, 0, 0, "R8 io disabled no subtractive");
        c_ien = 1;
        // R4: inverted window
        c_mbase = 64'h8800_0000; c_mlimit = 64'h8000_0000;
        send(64'h8400_0000, 0, 1, 0, "R4 inverted mem window");
        c_ibase = 16'h2000; c_ilimit = 16'h1000;
        send(64'h1800, 1, 0, 0, "R4 inverted io window");
        c_mbase = 64'h8000_0000; c_mlimit = 64'h8FFF_FFFF;
        c_ibase = 16'h1000; c_ilimit = 16'h1FFF;
        // R12: narrow versus wide
        send(64'h1_8000_0000, 0, 0, 0, "R12 narrow drops upper half");
        send(64'h1_8000_0000, 0, 1, 0, "R12 wide keeps upper half");
        send(64'h1_8000_0000, 0, 1, 1, "R12 wide with other claim");
        // R13: alternating config and claim line on consecutive cycles
        for (int i = 0; i < 16; i++) begin
            c_isa = i[0];
            c_vga = i[1];
            send((i % 3 == 0) ? 64'h8000_0040 : (i % 3 == 1) ? 64'h1000 + 64'(i * 16'h0110) : 64'h0000_2000 + 64'(i),
                 (i % 3 == 1), i[2], i[0] ^ i[3], "R13 back to back");
        end
        c_isa = 0; c_vga = 0;
        // R10 / R11 coverage: positive then subtractive then blocked
        send(64'h8000_0010, 0, 1, 1, "R10 positive ignores claim line");
        send(64'h0000_0010, 0, 1, 0, "R11 subtractive forwards");
        send(64'h0000_0020, 0, 1, 1, "R11 blocked no forward");
        idle(4);
        @(posedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule